// File: doc/BRIEF.md
# Two-Stage Streaming 1-D Stencil Chain

This block evaluates a chain of two one-dimensional stencils over a pair of input streams, taking one element of each stream per accepted cycle. The first stage forms an intermediate stream from adjacent element pairs of both inputs. The second stage combines the current inputs with two intermediate values two positions apart. Both stages deliver one result per accepted element. The first stage runs two positions ahead of the second. Because of that lead, the delay lines hold one element per input stream and four intermediate values, so the total storage is 6 elements instead of the 8 an unshifted schedule would need.

A stream opens with a `start` pulse and closes with a `flush` pulse. Element positions count accepted inputs from 0 after `start`. A result is emitted only when every operand it needs has arrived. Results whose operands would lie past the end of the stream are never produced. A three-state controller sequences the block:
- IDLE: ignores data.
- FILL: counts the first six elements.
- RUN: emits one result per accepted element.

Transitions: IDLE→FILL on `start`; FILL→RUN when the element at position 5 is accepted; FILL/RUN→IDLE on `flush`; any state→FILL on `start`.

Top module: `stencil_chain`

## Requirements
- R1: With Y[j] = X1[j-2]+X1[j-1]+X2[j-2]+X2[j-1], each emitted result equals Z[k] = X1[k+3]+X2[k+3]+Y[k]+Y[k+2], where the index counts accepted elements since `start`.
- R2: Z[k] appears on `z` with `z_valid` high for exactly one cycle, following the clock edge that accepts element k+3. The first result is Z[2], after the sixth accepted element (position 5). Earlier accepted elements produce no result.
- R3: Inputs are 16-bit two's complement and `z` is 20-bit two's complement. Full-scale positive and negative streams give exact results (327670 and -327680).
- R4: A cycle with `in_valid` low shifts no delay line and produces no result. The stream resumes across the gap as if the gap were absent.
- R5: `flush` ends the stream. `z_valid` is low after the flush edge, and data offered in the flush cycle is discarded.
- R6: `start` clears all stored history and begins a new count from position 0. Data offered in the start cycle is not accepted. `start` takes priority over `flush` when both are high in the same cycle.
- R7: Data offered while idle (after reset or after `flush`) produces no output and does not enter the next stream.
- R8: The delay storage is 1 element for X1, 1 for X2 and 4 for Y, 6 in total. The unshifted schedule would need 8. The package exports both totals.
- R9: After reset, `z_valid` is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new stream, clearing history |
| flush | input | 1 | Closes the current stream |
| in_valid | input | 1 | Input element pair present this cycle |
| x1 | input | 16 | First input stream element, signed |
| x2 | input | 16 | Second input stream element, signed |
| z_valid | output | 1 | Result present on `z` |
| z | output | 20 | Result of the second stage, signed |

## Verification
If the controller's fill count is off by even one, the first result appears one element early or late. The error shows at the sixth accepted element of every stream. A wrong tap or slot in the intermediate delay line corrupts every emitted result from the first one onward. This shows within six accepted elements of any stream. Stale history that survives `start` or `flush` only corrupts the first results of the following stream. Each stream is therefore checked from its first element rather than from the middle.

// File: rtl/stencil_chain_pkg.sv
package stencil_chain_pkg;

    localparam int DW = 16;
    localparam int YW = DW + 2;
    localparam int ZW = DW + 4;

    // Stage 2 reads inputs at k+3 and intermediates at k and k+2.
    localparam int X_LEAD   = 3;
    localparam int Y_SPAN   = 2;
    // Stage 1 runs this many positions ahead of its natural slot.
    localparam int S1_SHIFT = 2;

    localparam int X_DEPTH = X_LEAD - S1_SHIFT;
    localparam int Y_DEPTH = Y_SPAN + S1_SHIFT;
    localparam int STORE_ELEMS           = 2 * X_DEPTH + Y_DEPTH;
    localparam int STORE_ELEMS_UNSHIFTED = 2 * X_LEAD + Y_SPAN;

    // Position of the element that completes the first result Z[Y_SPAN].
    localparam int FIRST_OUT_POS = Y_SPAN + X_LEAD;
    localparam int CNT_W = $clog2(FIRST_OUT_POS + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } ctl_state_t;

endpackage

// File: rtl/stencil_chain_ctrl.sv
module stencil_chain_ctrl
    import stencil_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic flush,
    input  logic in_valid,
    output logic shift_en,
    output logic clear,
    output logic fire,
    output logic kill
);

    ctl_state_t state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic take;

    assign take = in_valid && !start && !flush;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (start) begin
            state_nxt = ST_FILL;
            cnt_nxt   = '0;
        end else if (flush) begin
            state_nxt = ST_IDLE;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_FILL: begin
                    if (in_valid) begin
                        if (cnt == CNT_W'(FIRST_OUT_POS))
                            state_nxt = ST_RUN;
                        else
                            cnt_nxt = cnt + CNT_W'(1);
                    end
                end
                ST_RUN: ;
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        shift_en = 1'b0;
        fire     = 1'b0;
        clear    = start;
        kill     = flush && !start;
        unique case (state)
            ST_IDLE: ;
            ST_FILL: begin
                shift_en = take;
                fire     = take && (cnt == CNT_W'(FIRST_OUT_POS));
            end
            ST_RUN: begin
                shift_en = take;
                fire     = take;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stencil_chain_s1.sv
module stencil_chain_s1
    import stencil_chain_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] x1,
    input  logic signed [DW-1:0] x2,
    output logic signed [YW-1:0] y_new
);

    logic signed [DW-1:0] d1 [X_DEPTH];
    logic signed [DW-1:0] d2 [X_DEPTH];

    generate
        for (genvar g = 0; g < X_DEPTH; g++) begin : g_xdly
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    d1[g] <= '0;
                    d2[g] <= '0;
                end else if (shift_en) begin
                    if (g == 0) begin
                        d1[g] <= x1;
                        d2[g] <= x2;
                    end else begin
                        d1[g] <= d1[(g == 0) ? 0 : g-1];
                        d2[g] <= d2[(g == 0) ? 0 : g-1];
                    end
                end
            end
        end
    endgenerate

    // Pair sum of the current element and the one before it.
    assign y_new = YW'(x1) + YW'(d1[X_DEPTH-1]) + YW'(x2) + YW'(d2[X_DEPTH-1]);

endmodule

// File: rtl/stencil_chain_ybuf.sv
module stencil_chain_ybuf
    import stencil_chain_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic signed [YW-1:0] y_new,
    output logic signed [YW-1:0] tap_near,
    output logic signed [YW-1:0] tap_far
);

    // slot[s] holds the intermediate produced s+1 accepted elements ago
    logic signed [YW-1:0] slot [Y_DEPTH];

    generate
        for (genvar g = 0; g < Y_DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    slot[g] <= '0;
                else if (shift_en) begin
                    if (g == 0)
                        slot[g] <= y_new;
                    else
                        slot[g] <= slot[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign tap_near = slot[Y_DEPTH-1-Y_SPAN];
    assign tap_far  = slot[Y_DEPTH-1];

endmodule

// File: rtl/stencil_chain_s2.sv
module stencil_chain_s2
    import stencil_chain_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 kill,
    input  logic                 fire,
    input  logic signed [DW-1:0] x1,
    input  logic signed [DW-1:0] x2,
    input  logic signed [YW-1:0] y_near,
    input  logic signed [YW-1:0] y_far,
    output logic                 z_valid,
    output logic signed [ZW-1:0] z
);

    logic signed [ZW-1:0] sum;

    assign sum = ZW'(x1) + ZW'(x2) + ZW'(y_far) + ZW'(y_near);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_valid <= 1'b0;
            z       <= '0;
        end else if (clear || kill) begin
            z_valid <= 1'b0;
        end else begin
            z_valid <= fire;
            if (fire)
                z <= sum;
        end
    end

endmodule

// File: rtl/stencil_chain.sv
module stencil_chain
    import stencil_chain_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 flush,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x1,
    input  logic signed [DW-1:0] x2,
    output logic                 z_valid,
    output logic signed [ZW-1:0] z
);

    logic shift_en, clear, fire, kill;
    logic signed [YW-1:0] y_new, y_near, y_far;

    stencil_chain_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .flush    (flush),
        .in_valid (in_valid),
        .shift_en (shift_en),
        .clear    (clear),
        .fire     (fire),
        .kill     (kill)
    );

    stencil_chain_s1 u_s1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .shift_en (shift_en),
        .x1       (x1),
        .x2       (x2),
        .y_new    (y_new)
    );

    stencil_chain_ybuf u_ybuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .shift_en (shift_en),
        .y_new    (y_new),
        .tap_near (y_near),
        .tap_far  (y_far)
    );

    stencil_chain_s2 u_s2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .kill    (kill),
        .fire    (fire),
        .x1      (x1),
        .x2      (x2),
        .y_near  (y_near),
        .y_far   (y_far),
        .z_valid (z_valid),
        .z       (z)
    );

endmodule

// File: rtl/stencil_chain_checker.sv
module stencil_chain_checker
    import stencil_chain_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic flush,
    input logic in_valid,
    input logic z_valid
);

    logic       active;
    logic [3:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            seen   <= '0;
        end else if (start) begin
            active <= 1'b1;
            seen   <= '0;
        end else if (flush) begin
            active <= 1'b0;
            seen   <= '0;
        end else if (active && in_valid && seen != 4'd15) begin
            seen <= seen + 4'd1;
        end
    end

    // R2: no result before six elements of the stream have been accepted
    a_r2_fill_complete: assert property (@(posedge clk) disable iff (!rst_n)
        z_valid |-> (active && seen >= 4'(FIRST_OUT_POS + 1)));

    // R4: a result only follows a cycle that offered data
    a_r4_valid_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        z_valid |-> $past(in_valid));

    // R5: nothing is emitted right after a flush
    a_r5_flush_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !start) |=> !z_valid);

    // R6: the start cycle never yields a result
    a_r6_start_silent: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !z_valid);

    // R8: storage with the shifted first stage is smaller than unshifted
    initial a_r8_storage: assert (STORE_ELEMS == 6 && STORE_ELEMS_UNSHIFTED == 8);

endmodule

bind stencil_chain stencil_chain_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .flush    (flush),
    .in_valid (in_valid),
    .z_valid  (z_valid)
);

// File: tb/stencil_chain_bench.sv
module stencil_chain_bench;
    import stencil_chain_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, flush = 1'b0, in_valid = 1'b0;
    logic signed [15:0] x1 = '0, x2 = '0;
    logic z_valid;
    logic signed [19:0] z;

    int checks = 0, errors = 0;
    int h1 [0:1023];
    int h2 [0:1023];
    int n_acc = 0;
    bit active = 0;
    bit done = 0;

    always #10 clk = ~clk;

    stencil_chain u_stencil_chain (
        .clk(clk), .rst_n(rst_n), .start(start), .flush(flush),
        .in_valid(in_valid), .x1(x1), .x2(x2), .z_valid(z_valid), .z(z)
    );

    function automatic int ymod(int j);
        return h1[j-2] + h1[j-1] + h2[j-2] + h2[j-1];
    endfunction

    function automatic int zmod(int k);
        return h1[k+3] + h2[k+3] + ymod(k) + ymod(k+2);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int a, input int b, input string req);
        bit ev;
        int ez;
        @(negedge clk);
        in_valid = 1'b1; x1 = 16'(a); x2 = 16'(b);
        @(posedge clk); #1;
        in_valid = 1'b0;
        ev = 0; ez = 0;
        if (active) begin
            h1[n_acc] = a; h2[n_acc] = b;
            if (n_acc >= 5) begin ev = 1; ez = zmod(n_acc - 3); end
            n_acc++;
        end
        check({req, " valid"}, int'(z_valid), int'(ev));
        if (ev) check({req, " value"}, int'(z), ez);
    endtask

    task automatic gap();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        check("R4 gap no output", int'(z_valid), 0);
    endtask

    task automatic do_start(input bit with_data, input bit with_flush);
        @(negedge clk);
        start = 1'b1; flush = with_flush; in_valid = with_data;
        x1 = 16'sd1234; x2 = -16'sd99;
        @(posedge clk); #1;
        start = 1'b0; flush = 1'b0; in_valid = 1'b0;
        active = 1; n_acc = 0;
        check("R6 start cycle silent", int'(z_valid), 0);
    endtask

    task automatic do_flush(input bit with_data);
        @(negedge clk);
        flush = 1'b1; in_valid = with_data; x1 = 16'sd777; x2 = 16'sd555;
        @(posedge clk); #1;
        flush = 1'b0; in_valid = 1'b0;
        active = 0;
        check("R5 flush silences", int'(z_valid), 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset z_valid", int'(z_valid), 0);
        @(negedge clk); rst_n = 1'b1;

        // R8: storage totals
        check("R8 shifted storage", STORE_ELEMS, 6);
        check("R8 unshifted storage", STORE_ELEMS_UNSHIFTED, 8);

        // R7: idle data ignored
        for (int i = 0; i < 8; i++) push(i + 50, i - 50, "R7 idle ignored");

        // R1/R2: directed ramp
        do_start(1'b1, 1'b0);
        for (int i = 0; i < 12; i++) push(i + 1, 10 * (i + 1), "R1 R2 ramp");
        do_flush(1'b1);
        for (int i = 0; i < 7; i++) push(3, 3, "R7 after flush");

        // R3: full scale positive then negative
        do_start(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) push(32767, 32767, "R3 max");
        check("R3 max exact", int'(z), 327670);
        do_flush(1'b0);
        do_start(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) push(-32768, -32768, "R3 min");
        check("R3 min exact", int'(z), -327680);

        // R6: restart mid-stream, start wins over flush
        do_start(1'b1, 1'b1);
        for (int i = 0; i < 8; i++) push(i * 7 - 20, 5 - i, "R6 restart");

        // R4: random stream with gaps
        do_start(1'b0, 1'b0);
        for (int i = 0; i < 300; i++) begin
            if ($urandom % 4 == 0) gap();
            push(int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R1 R4 random");
        end
        do_flush(1'b0);

        // Short random streams: edges of the fill window
        for (int s = 0; s < 20; s++) begin
            int len;
            len = 3 + int'($urandom % 8);
            do_start(1'b0, 1'b0);
            for (int i = 0; i < len; i++)
                push(int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R2 short");
            do_flush(1'b0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule